// File: doc/BRIEF.md
# Winograd 3x3 Convolution Tile Engine

This block computes one 2x2 tile of convolution outputs from a 4x4 patch of input pixels and a 3x3 kernel, for a single input channel. It does this with the minimal-filtering (Winograd) method. The patch passes through an add/subtract transform. The kernel passes through a transform that is scaled by two in each dimension so that it stays integer. The 16 transformed values are then multiplied element by element, and an add/subtract output transform reduces the 16 products to 4 results. A final arithmetic right shift by two removes the kernel scaling. Each tile therefore costs 16 multiplications, where the direct method would need 36.

A feature-map walker upstream supplies overlapping patches, which advance by two pixels per step. An accumulator downstream sums the tiles across channels. Operands are signed fixed-point integers. Every internal stage has enough growth bits that no intermediate value can overflow. The engine is a three-stage pipeline with a valid/ready handshake. While the consumer keeps up, it takes a new tile every cycle. When the consumer stalls, the whole pipeline stalls.

Top module: `wino_tile`

## Requirements
- R1: Output element y(r,c), at out_tile bits [(r*2+c)*OW +: OW] with r,c in 0..1, equals the sum over a,b in 0..2 of d(r+a,c+b)*g(a,b). Here d(i,j) is the signed DW-bit value at in_patch bits [(i*4+j)*DW +: DW] and g(a,b) is the signed WW-bit value at in_kern bits [(a*3+b)*WW +: WW].
- R2: The R1 result is exact for every signed operand value, including all operands at the most negative or most positive value, with OW = DW+WW+4.
- R3: A tile accepted on a clock edge (in_valid and in_ready both high) appears on out_valid/out_tile after exactly three edges, provided out_ready stays high.
- R4: While out_ready stays high, in_ready stays high, so one tile is accepted on every cycle.
- R5: While out_valid is high and out_ready is low, out_tile and out_valid hold their values and in_ready is low.
- R6: While out_valid is low, in_ready is high.
- R7: During reset and on the first cycle after it, out_valid is low.
- R8: Cycles with in_valid low produce no output tile, and tiles leave in the order they were accepted, with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Patch and kernel are present |
| in_ready | output | 1 | Engine can take a tile this cycle |
| in_patch | input | 16*DW | 4x4 input patch, row-major, signed |
| in_kern | input | 9*WW | 3x3 kernel, row-major, signed |
| out_valid | output | 1 | out_tile holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_tile | output | 4*OW | 2x2 output tile, row-major, signed |

## Verification
Every tile is compared with a direct nine-term correlation computed in the bench. The first tiles are directed cases. All-maximum and all-minimum operands, and mixed extremes, expose missing growth bits in the transforms and products. A centre-tap kernel must reproduce the middle four pixels, which exposes swapped rows, columns or transform signs. Random tiles are then sent with scattered input bubbles and out_ready held high, and the bench checks the three-edge latency and the one-per-cycle acceptance. A final random run with out_ready toggling tells a correct stall apart from lost, repeated or changed tiles.

// File: rtl/wino_tile.sv
module wino_tile #(
  parameter int DW = 8,
  parameter int WW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [16*DW-1:0]    in_patch,
  input  logic [9*WW-1:0]     in_kern,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [4*(DW+WW+4)-1:0] out_tile
);
  localparam int VW = DW + 2;
  localparam int UW = WW + 4;
  localparam int PW = VW + UW;
  localparam int SW = PW + 4;
  localparam int OW = DW + WW + 4;

  logic en, v1_q, v2_q;
  assign en       = !out_valid || out_ready;
  assign in_ready = en;

  logic signed [VW-1:0] d[4][4], dt[4][4], v[4][4];
  logic signed [UW-1:0] g[3][3], gt[4][3], u[4][4];

  always_comb begin
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        d[r][c] = VW'($signed(in_patch[(r*4+c)*DW +: DW]));
    for (int c = 0; c < 4; c++) begin
      dt[0][c] = d[0][c] - d[2][c];
      dt[1][c] = d[1][c] + d[2][c];
      dt[2][c] = d[2][c] - d[1][c];
      dt[3][c] = d[1][c] - d[3][c];
    end
    for (int r = 0; r < 4; r++) begin
      v[r][0] = dt[r][0] - dt[r][2];
      v[r][1] = dt[r][1] + dt[r][2];
      v[r][2] = dt[r][2] - dt[r][1];
      v[r][3] = dt[r][1] - dt[r][3];
    end
  end

  always_comb begin
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++)
        g[r][c] = UW'($signed(in_kern[(r*3+c)*WW +: WW]));
    for (int c = 0; c < 3; c++) begin
      gt[0][c] = g[0][c] + g[0][c];
      gt[1][c] = g[0][c] + g[1][c] + g[2][c];
      gt[2][c] = g[0][c] - g[1][c] + g[2][c];
      gt[3][c] = g[2][c] + g[2][c];
    end
    for (int r = 0; r < 4; r++) begin
      u[r][0] = gt[r][0] + gt[r][0];
      u[r][1] = gt[r][0] + gt[r][1] + gt[r][2];
      u[r][2] = gt[r][0] - gt[r][1] + gt[r][2];
      u[r][3] = gt[r][2] + gt[r][2];
    end
  end

  logic signed [UW-1:0] u_q[4][4];
  logic signed [VW-1:0] v_q[4][4];
  logic signed [PW-1:0] m_q[4][4];
  logic signed [OW-1:0] y_q[2][2];
  logic signed [SW-1:0] p[2][4], y[2][2];

  always_comb begin
    for (int c = 0; c < 4; c++) begin
      p[0][c] = SW'(m_q[0][c]) + SW'(m_q[1][c]) + SW'(m_q[2][c]);
      p[1][c] = SW'(m_q[1][c]) - SW'(m_q[2][c]) - SW'(m_q[3][c]);
    end
    for (int r = 0; r < 2; r++) begin
      y[r][0] = p[r][0] + p[r][1] + p[r][2];
      y[r][1] = p[r][1] - p[r][2] - p[r][3];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v1_q      <= 1'b0;
      v2_q      <= 1'b0;
      out_valid <= 1'b0;
    end else if (en) begin
      v1_q      <= in_valid;
      v2_q      <= v1_q;
      out_valid <= v2_q;
    end

  always_ff @(posedge clk)
    if (en) begin
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++) begin
          u_q[r][c] <= u[r][c];
          v_q[r][c] <= v[r][c];
          m_q[r][c] <= PW'(u_q[r][c]) * PW'(v_q[r][c]);
        end
      for (int r = 0; r < 2; r++)
        for (int c = 0; c < 2; c++)
          y_q[r][c] <= OW'(y[r][c] >>> 2);
    end

  for (genvar k = 0; k < 4; k++) begin : g_out
    assign out_tile[k*OW +: OW] = y_q[k/2][k%2];
  end
endmodule

module wino_tile_chk #(
  parameter int DW = 8,
  parameter int WW = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [4*(DW+WW+4)-1:0]    out_tile
);
  // R3
  latency_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_ready) ##1 out_ready ##1 out_ready |=> out_valid);
  // R8
  bubble_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready) ##1 out_ready ##1 out_ready |=> !out_valid);
  // R4
  ready_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);
  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_tile));
  // R5
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R6
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  // R7
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);
endmodule

bind wino_tile wino_tile_chk #(.DW(DW), .WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_tile(out_tile));

// File: tb/test_wino_tile.sv
module test_wino_tile;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_patch = '0;
  logic [71:0]  in_kern = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [79:0]  out_tile;

  int checks = 0;
  int errors = 0;
  int tick = 0;
  bit lat_on = 1'b0;
  bit prev_stall = 1'b0;
  bit done = 1'b0;
  logic [79:0] prev_tile;
  logic [79:0] exp_q[$];
  int          tick_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  wino_tile #(.DW(8), .WW(8)) i_wino_tile (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_patch(in_patch), .in_kern(in_kern), .out_valid(out_valid),
    .out_ready(out_ready), .out_tile(out_tile));

  function automatic logic [79:0] ref_tile(logic [127:0] p, logic [71:0] k);
    logic [79:0] res;
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 2; c++) begin
        int s = 0;
        for (int a = 0; a < 3; a++)
          for (int b = 0; b < 3; b++)
            s += int'($signed(p[((r+a)*4+c+b)*8 +: 8])) * int'($signed(k[(a*3+b)*8 +: 8]));
        res[(r*2+c)*20 +: 20] = s[19:0];
      end
    return res;
  endfunction

  task automatic chk(bit ok, string req, logic [79:0] act, logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle(bit vin, bit rdy, logic [127:0] p, logic [71:0] k, string tag);
    @(negedge clk);
    if (prev_stall)
      chk(out_valid === 1'b1 && out_tile === prev_tile, "R5 hold", out_tile, prev_tile);
    in_valid = vin; out_ready = rdy; in_patch = p; in_kern = k;
    #1;
    tick++;
    if (rdy && lat_on) chk(in_ready === 1'b1, "R4 ready", 80'(in_ready), 80'd1);
    if (out_valid && !rdy) chk(in_ready === 1'b0, "R5 block", 80'(in_ready), 80'd0);
    if (!out_valid) chk(in_ready === 1'b1, "R6 ready", 80'(in_ready), 80'd1);
    if (out_valid && rdy) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 extra tile", out_tile, 80'd0);
      else begin
        logic [79:0] e = exp_q.pop_front();
        int t0 = tick_q.pop_front();
        string tg = tag_q.pop_front();
        chk(out_tile === e, tg, out_tile, e);
        if (lat_on) chk(tick - t0 == 3, "R3 latency", 80'(tick - t0), 80'd3);
      end
    end
    prev_stall = out_valid && !rdy;
    prev_tile  = out_tile;
    if (vin && in_ready) begin
      exp_q.push_back(ref_tile(p, k));
      tick_q.push_back(tick);
      tag_q.push_back(tag);
    end
  endtask

  function automatic logic [127:0] rnd_patch();
    logic [127:0] v;
    for (int i = 0; i < 4; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [71:0] rnd_kern();
    return {8'($urandom), 32'($urandom), 32'($urandom)};
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) begin
      @(negedge clk);
      chk(out_valid === 1'b0, "R7 in reset", 80'(out_valid), 80'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R7 after reset", 80'(out_valid), 80'd0);
    chk(in_ready === 1'b1, "R6 after reset", 80'(in_ready), 80'd1);

    lat_on = 1'b1;
    cycle(1, 1, {16{8'h7f}}, {9{8'h7f}}, "R2 all max");
    cycle(1, 1, {16{8'h80}}, {9{8'h80}}, "R2 all min");
    cycle(1, 1, {16{8'h80}}, {9{8'h7f}}, "R2 mixed extremes");
    cycle(1, 1, {8{8'h80, 8'h7f}}, {8'h80, 8'h7f, 8'h80, 8'h7f, 8'h80, 8'h7f, 8'h80, 8'h7f, 8'h80}, "R2 alternating");
    cycle(1, 1, rnd_patch(), {32'd0, 8'd1, 32'd0}, "R1 centre tap");
    cycle(1, 1, 128'd0, rnd_kern(), "R1 zero patch");
    for (int n = 0; n < 200; n++)
      cycle(($urandom % 10) < 7, 1, rnd_patch(), rnd_kern(), "R1 random");
    repeat (6) cycle(0, 1, rnd_patch(), rnd_kern(), "R8 bubble");
    chk(exp_q.size() == 0, "R8 drained", 80'(exp_q.size()), 80'd0);

    lat_on = 1'b0;
    for (int n = 0; n < 300; n++)
      cycle(($urandom % 10) < 8, ($urandom % 10) < 6, rnd_patch(), rnd_kern(), "R8 order under stall");
    repeat (10) cycle(0, 1, 128'd0, 72'd0, "R8 bubble");
    chk(exp_q.size() == 0, "R8 nothing lost", 80'(exp_q.size()), 80'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule